// File: doc/BRIEF.md
# Burst Flash Read WAIT Generator

This block is the device-side control for synchronous burst reads of a flash memory. On every clock it decides the level of the WAIT output. It also drives an output-enable indication and a data word. The host programs a 16-bit read configuration word. That word sets the WAIT polarity, synchronous or asynchronous operation, the first-access latency and the burst length. A separate input gives the read mode of the addressed partition.

An access starts on the rising clock edge where chip enable and the active-low address-valid strobe are both low. The block then counts the programmed latency and presents one word per clock for the length of the burst. WAIT reports data validity only for synchronous reads of the array. In every other case WAIT sits at its asserted level, and the host must ignore it there. A behavioural array computes the data words from the address.

Top module: `flash_wait_gen`

## Requirements
- R1: Configuration bit 10 sets the asserted level of WAIT. When the bit is 0, WAIT is asserted low. When the bit is 1, WAIT is asserted high. Whenever WAIT is deasserted, `oe_o` is high and `dq_o` carries a valid word.
- R2: A latch edge is a rising edge with `ce_n` and `adv_n` both low. On a latch edge the block captures `addr_i` and the latency L from configuration bits 14:11. The first word is valid after L further rising edges. When L is 0, the first word is valid right after the latch edge.
- R3: Between the latch edge and the first valid word, WAIT is asserted and `dq_o` is 0.
- R4: Word i of a burst (i = 0, 1, ...) is valid after edge L+i, counted from the latch edge. Its value is the low 16 bits of ((base+i) mod 2^16) * 0x9E37, XOR 0x5A3C, where base is the latched address.
- R5: Configuration bits 1:0, captured at the latch edge, set the burst length. The codes are 0 for 4 words, 1 for 8, 2 for 16 and 3 for continuous. After the last word, WAIT is asserted again and `dq_o` is 0 until the next latch edge.
- R6: When `mode_i` is not 0, WAIT stays at its asserted level and `dq_o` is 0. The codes are 0 for array, 1 for status, 2 for ID and 3 for query.
- R7: When configuration bit 15 is 1 (asynchronous), WAIT stays at its asserted level and `dq_o` is 0.
- R8: `oe_o` equals the inverse of `ce_n`. A rising edge with `ce_n` high ends any burst. After `ce_n` returns low, WAIT stays asserted until a new latch edge.
- R9: A latch edge during a burst restarts the latency count from the new address. This holds even on the edge where the old burst would have advanced or ended.
- R10: A rising edge with `rst` high clears any burst. Afterwards WAIT is asserted and `dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_i | input | 16 | Read configuration word |
| mode_i | input | 2 | Read mode of the addressed partition |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_i | input | 16 | Start address of the burst |
| wait_o | output | 1 | WAIT level |
| oe_o | output | 1 | Output enable; low stands for high impedance |
| dq_o | output | 16 | Data word, 0 when not valid |

## Verification
The same edge can be a burst-advance edge and a new latch edge, and the restart must win. The bench provokes this on purpose. It raises `adv_n` low on the edge that would present the last word of a burst. It does the same in the middle of a continuous burst. Random stimulus also drops the strobe at random points. A reference model checks every cycle that the latency restarts from the new address and that no stale word shows up. A second overlap is chip enable going high on an advance edge. The bench judges it by checking that no word appears after `ce_n` returns low.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LAT_W  = 4;
    localparam int BEAT_W = 5;

    typedef enum logic [1:0] {
        BL_4    = 2'd0,
        BL_8    = 2'd1,
        BL_16   = 2'd2,
        BL_CONT = 2'd3
    } burst_e;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_IDENT  = 2'd2,
        MD_QUERY  = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic             async_rd;
        logic [LAT_W-1:0] lat;
        logic             pol_high;
        logic [7:0]       rsvd;
        burst_e           blen;
    } rd_cfg_t;

    function automatic logic [BEAT_W-1:0] burst_words(burst_e b);
        case (b)
            BL_4:    return BEAT_W'(4);
            BL_8:    return BEAT_W'(8);
            BL_16:   return BEAT_W'(16);
            default: return '0;
        endcase
    endfunction

    localparam logic [DATA_W-1:0] ARR_MULT = 16'h9E37;
    localparam logic [DATA_W-1:0] ARR_SALT = 16'h5A3C;

endpackage

// File: rtl/fwg_seq.sv
module fwg_seq
    import fwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  burst_e            blen_i,
    output logic              word_rdy,
    output logic [ADDR_W-1:0] word_addr
);

    logic              active_q;
    logic [LAT_W-1:0]  cnt_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] len_q;
    logic              cont_q;
    logic [ADDR_W-1:0] addr_q;
    logic              latch;
    logic              done;

    assign latch     = !ce_n && !adv_n;
    assign done      = !cont_q && (beat_q == len_q);
    assign word_rdy  = active_q && (cnt_q == '0) && !done;
    assign word_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            beat_q   <= '0;
            len_q    <= '0;
            cont_q   <= 1'b0;
            addr_q   <= '0;
        end else if (ce_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (latch) begin
            active_q <= 1'b1;
            cnt_q    <= lat_i;
            beat_q   <= '0;
            len_q    <= burst_words(blen_i);
            cont_q   <= (blen_i == BL_CONT);
            addr_q   <= addr_i;
        end else if (active_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (!done) begin
                addr_q <= addr_q + 1'b1;
                if (!cont_q) beat_q <= beat_q + 1'b1;
            end
        end
    end

    // R2: the latch edge loads the latency field
    a_r2_latch_loads: assert property (@(posedge clk) disable iff (rst)
        latch |=> (cnt_q == $past(lat_i)) && active_q);

    // R4: each presented word is followed by the next address
    a_r4_beat_advance: assert property (@(posedge clk) disable iff (rst)
        (word_rdy && !ce_n && adv_n) |=> (addr_q == $past(addr_q) + 1'b1));

    // R8: chip enable high ends the burst
    a_r8_ce_cancels: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !active_q);

endmodule

// File: rtl/fwg_array.sv
module fwg_array
    import fwg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int PROD_W = ADDR_W + DATA_W;

    logic [PROD_W-1:0] prod;

    assign prod   = PROD_W'(addr_i) * PROD_W'(ARR_MULT);
    assign word_o = prod[DATA_W-1:0] ^ ARR_SALT;

endmodule

// File: rtl/fwg_wait.sv
module fwg_wait
    import fwg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ce_n,
    input  logic     pol_high,
    input  logic     async_rd,
    input  rd_mode_e mode,
    input  logic     word_rdy,
    output logic     wait_o,
    output logic     data_en
);

    assign data_en = word_rdy && !ce_n && !async_rd && (mode == MD_ARRAY);
    assign wait_o  = data_en ? !pol_high : pol_high;

    // R6: non-array reads keep WAIT at its asserted level
    a_r6_nonarray_held: assert property (@(posedge clk) disable iff (rst)
        (mode != MD_ARRAY) |-> (wait_o == pol_high) && !data_en);

    // R7: asynchronous operation keeps WAIT at its asserted level
    a_r7_async_held: assert property (@(posedge clk) disable iff (rst)
        async_rd |-> (wait_o == pol_high));

endmodule

// File: rtl/flash_wait_gen.sv
module flash_wait_gen
    import fwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cfg_i,
    input  logic [1:0]        mode_i,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wait_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] dq_o
);

    rd_cfg_t           cfg;
    logic [7:0]        unused_rsvd;
    logic              word_rdy;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] arr_word;
    logic              data_en;

    assign cfg         = rd_cfg_t'(cfg_i);
    assign unused_rsvd = cfg.rsvd;

    fwg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .addr_i    (addr_i),
        .lat_i     (cfg.lat),
        .blen_i    (cfg.blen),
        .word_rdy  (word_rdy),
        .word_addr (word_addr)
    );

    fwg_array u_array (
        .addr_i (word_addr),
        .word_o (arr_word)
    );

    fwg_wait u_wait (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .pol_high (cfg.pol_high),
        .async_rd (cfg.async_rd),
        .mode     (rd_mode_e'(mode_i)),
        .word_rdy (word_rdy),
        .wait_o   (wait_o),
        .data_en  (data_en)
    );

    assign oe_o = !ce_n;
    assign dq_o = data_en ? arr_word : '0;

    // R1: deasserted WAIT only with the bus driven
    a_r1_deassert_means_valid: assert property (@(posedge clk) disable iff (rst)
        (wait_o != cfg_i[10]) |-> oe_o);

    // R10: the edge after reset shows no valid word
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (dq_o == '0) && (wait_o == cfg_i[10]));

endmodule

// File: tb/flash_wait_gen_tb_top.sv
module flash_wait_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg;
    logic [1:0]  mode;
    logic        ce_n;
    logic        adv_n;
    logic [15:0] addr;
    logic        wait_o;
    logic        oe_o;
    logic [15:0] dq_o;

    int vectors = 0;
    int fails   = 0;
    bit summary_done = 0;

    always #2 clk = ~clk;

    flash_wait_gen dut_i (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .mode_i (mode),
        .ce_n   (ce_n),
        .adv_n  (adv_n),
        .addr_i (addr),
        .wait_o (wait_o),
        .oe_o   (oe_o),
        .dq_o   (dq_o)
    );

    // reference model: edges since the latch edge
    bit          m_act  = 0;
    int          m_k    = 0;
    int          m_lat  = 0;
    int          m_len  = 0;
    bit          m_cont = 0;
    logic [15:0] m_base = '0;

    always @(posedge clk) begin
        if (rst || ce_n) begin
            m_act <= 0;
        end else if (!adv_n) begin
            m_act  <= 1;
            m_k    <= 0;
            m_base <= addr;
            m_lat  <= int'(cfg[14:11]);
            m_cont <= (cfg[1:0] == 2'd3);
            m_len  <= (cfg[1:0] == 2'd0) ? 4 : (cfg[1:0] == 2'd1) ? 8 : 16;
        end else if (m_act && m_k < 1000000) begin
            m_k <= m_k + 1;
        end
    end

    function automatic logic [15:0] ref_word(logic [15:0] a);
        logic [15:0] p;
        p = a * 16'h9E37;
        return p ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] mk_cfg(bit async_rd, bit pol, int lat, int bl);
        logic [15:0] c;
        c = '0;
        c[15]    = async_rd;
        c[14:11] = 4'(lat);
        c[10]    = pol;
        c[1:0]   = 2'(bl);
        return c;
    endfunction

    function automatic bit exp_valid();
        return !ce_n && m_act && !cfg[15] && (mode == 2'd0) && (m_k >= m_lat)
               && (m_cont || (m_k - m_lat) < m_len);
    endfunction

    task automatic check(string tag);
        bit          ev;
        logic        ew;
        logic [15:0] ed;
        string       t;
        ev = exp_valid();
        ew = ev ? ~cfg[10] : cfg[10];
        ed = ev ? ref_word(m_base + 16'(m_k - m_lat)) : 16'h0;
        t  = tag;
        if (t == "") begin
            if (cfg[15])                 t = "R7";
            else if (mode != 2'd0)       t = "R6";
            else if (m_act && m_k < m_lat) t = "R3";
            else if (m_act && !ev && !ce_n) t = "R5";
            else                         t = "R2";
        end
        vectors++;
        if (wait_o !== ew) begin
            fails++;
            $display("FAIL %s wait_o actual=%b expected=%b t=%0t", t, wait_o, ew, $time);
        end
        if (oe_o !== !ce_n) begin
            fails++;
            $display("FAIL R8 oe_o actual=%b expected=%b t=%0t", oe_o, !ce_n, $time);
        end
        if (dq_o !== ed) begin
            fails++;
            $display("FAIL R4 dq_o actual=%h expected=%h t=%0t", dq_o, ed, $time);
        end
    endtask

    task automatic step(bit ce, bit adv, logic [15:0] a, string tag);
        @(negedge clk);
        ce_n  = ce;
        adv_n = adv;
        addr  = a;
        #1;
        check(tag);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1; cfg = mk_cfg(0, 0, 3, 0); mode = 2'd0;
        ce_n = 1; adv_n = 1; addr = '0;
        step(0, 1, 16'h0, "R10");
        step(0, 1, 16'h0, "R10");
        rst = 0;
        step(0, 1, 16'h0, "R10");

        // R1 and R2: latency 3, burst 4, both polarities
        for (int p = 0; p < 2; p++) begin
            cfg = mk_cfg(0, p[0], 3, 0);
            step(0, 0, 16'h1200, "R1");
            for (int i = 0; i < 9; i++) step(0, 1, 16'h0, "R1");
        end
        // R2: latency 0, R5: 8 and 16 word bursts
        cfg = mk_cfg(0, 1, 0, 1);
        step(0, 0, 16'hFFFC, "R2");
        for (int i = 0; i < 10; i++) step(0, 1, 16'h0, "R5");
        cfg = mk_cfg(0, 0, 2, 2);
        step(0, 0, 16'h0040, "R5");
        for (int i = 0; i < 20; i++) step(0, 1, 16'h0, "R5");
        // R6: non-array modes
        for (int md = 1; md < 4; md++) begin
            mode = 2'(md);
            cfg  = mk_cfg(0, md[0], 1, 0);
            step(0, 0, 16'h0300, "R6");
            for (int i = 0; i < 5; i++) step(0, 1, 16'h0, "R6");
        end
        mode = 2'd0;
        // R7: asynchronous
        cfg = mk_cfg(1, 1, 1, 3);
        step(0, 0, 16'h0500, "R7");
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0, "R7");
        // R8: chip enable high mid burst, then low without strobe
        cfg = mk_cfg(0, 0, 1, 3);
        step(0, 0, 16'h0700, "R8");
        for (int i = 0; i < 3; i++) step(0, 1, 16'h0, "R8");
        step(1, 1, 16'h0, "R8");
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0, "R8");
        // R9: restart on the edge of the last word, and mid continuous burst
        cfg = mk_cfg(0, 1, 2, 0);
        step(0, 0, 16'h0900, "R9");
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0, "R9");
        step(0, 0, 16'h0A00, "R9");
        for (int i = 0; i < 7; i++) step(0, 1, 16'h0, "R9");
        cfg = mk_cfg(0, 0, 1, 3);
        step(0, 0, 16'h0B00, "R9");
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0, "R9");
        step(0, 0, 16'h0C00, "R9");
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0, "R9");
        // R10: reset mid burst
        rst = 1;
        step(0, 1, 16'h0, "R10");
        rst = 0;
        for (int i = 0; i < 3; i++) step(0, 1, 16'h0, "R10");

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            bit ce, adv;
            if ($urandom_range(0, 15) == 0)
                cfg = mk_cfg($urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1,
                             $urandom_range(0, 15), $urandom_range(0, 3));
            if ($urandom_range(0, 19) == 0)
                mode = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            ce  = ($urandom_range(0, 24) == 0);
            adv = ($urandom_range(0, 9) != 0);
            step(ce, adv, 16'($urandom), "");
        end
        finish_run();
    end

endmodule